// File: doc/BRIEF.md
# Load/Store Micro-Sequencer with Illegal-Opcode Lockup

This block runs the memory-transfer part of a small 8-bit accumulator CPU that has no separate I/O port space. It fetches an opcode and any operand bytes through a byte-wide memory port, forms the transfer address, and performs one read or write. It owns the accumulator A, the index byte C, the pointer HL and the stack pointer SP. Peripheral registers live in the fixed top page 0xFF00-0xFFFF and are reached with an immediate low byte or with C.

Each memory access occupies one machine cycle of four clocks. Within a machine cycle the read or write strobe is high for exactly one clock, the second clock of the four. Opcodes that the CPU leaves undefined freeze the sequencer until reset. Every other opcode outside the supported set is fetched and skipped.

Top module: `ls_microseq`

## Requirements
- R1: While reset is low and right after it: A=0x00, C=0x12, HL=0xFFFE, SP=0xBEEF, locked_o=0, no strobe, no done_o. The first fetch reads address 0x0000, and later opcodes and operands come from successive addresses.
- R2: Every memory access is a machine cycle of 4 clocks. Its strobe is high on the second clock only. mem_rd_o and mem_wr_o are never high together, and a strobe never lasts two clocks in a row.
- R3: 0x22 writes A to address HL and 0x2A loads A from address HL. Both then set HL to HL+1 modulo 2^16, and both take 2 machine cycles.
- R4: 0x32 writes A to address HL and 0x3A loads A from address HL. Both then set HL to HL-1 modulo 2^16, and both take 2 machine cycles.
- R5: 0xE0 n writes A to address {0xFF,n} and 0xF0 n loads A from it. The high byte is always 0xFF, with no carry. Both take 3 machine cycles.
- R6: 0xE2 writes A to address {0xFF,C} and 0xF2 loads A from it. Neither reads an operand byte, and both take 2 machine cycles.
- R7: 0xEA lo hi writes A to address {hi,lo} and 0xFA lo hi loads A from it. Both take 4 machine cycles.
- R8: 0x08 lo hi writes SP[7:0] to {hi,lo} and then SP[15:8] to {hi,lo}+1 modulo 2^16. It takes 5 machine cycles.
- R9: Fetching 0xD3, 0xDB, 0xDD, 0xE3, 0xE4, 0xEB, 0xEC, 0xED, 0xF4, 0xFC or 0xFD raises locked_o at the end of the fetch cycle. locked_o then stays high until reset, and no further strobe or done_o appears.
- R10: Any other opcode outside the set above leaves A, HL and memory unchanged, finishes after 1 machine cycle, and the next fetch follows at the next address.
- R11: done_o is a one-clock pulse on the last clock of an instruction's final machine cycle. Successive pulses are spaced 4 x (machine cycles of the later instruction) clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 16 | Memory address |
| mem_rd_o | output | 1 | Read strobe, one clock per machine cycle |
| mem_wr_o | output | 1 | Write strobe, one clock per machine cycle |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid in the strobe clock |
| reg_a_o | output | 8 | Accumulator |
| reg_c_o | output | 8 | Index byte for the top page |
| reg_hl_o | output | 16 | HL pointer |
| reg_sp_o | output | 16 | Stack pointer |
| done_o | output | 1 | Instruction complete pulse |
| locked_o | output | 1 | Frozen after an undefined opcode |

## Verification
The hardest conditions to reach are the wrap corners. They are HL crossing 0xFFFF in both directions, and the second SP byte of 0x08 landing at 0x0000 when the operand is 0xFFFF. These need the reset value of HL next to the top of memory and a program that walks HL across the edge with post-increment and post-decrement transfers. Lockup is reached once at the end of the main program and then once for each undefined opcode, with a reset before each. After each lockup the bench watches for a stray strobe or done pulse over a long quiet window.

// File: rtl/ls_pkg.sv
package ls_pkg;

  typedef enum logic [2:0] {
    ST_FETCH, ST_OPLO, ST_OPHI, ST_XFER, ST_XFER2, ST_LOCK
  } ls_state_e;

  typedef enum logic [2:0] {
    AM_NONE, AM_HL_INC, AM_HL_DEC, AM_PAGE_N, AM_PAGE_C, AM_ABS, AM_SP_ABS
  } ls_amode_e;

  typedef struct packed {
    logic       illegal;
    ls_amode_e  amode;
    logic       store;
    logic [1:0] n_opnd;
  } ls_dec_t;

  localparam logic [7:0] PAGE_HI = 8'hFF;

endpackage

// File: rtl/ls_decode.sv
module ls_decode
  import ls_pkg::*;
(
  input  logic [7:0] op_i,
  output ls_dec_t    dec_o
);

  always_comb begin
    dec_o = '{illegal: 1'b0, amode: AM_NONE, store: 1'b0, n_opnd: 2'd0};
    case (op_i)
      8'h22: dec_o = '{illegal: 1'b0, amode: AM_HL_INC, store: 1'b1, n_opnd: 2'd0};
      8'h2A: dec_o = '{illegal: 1'b0, amode: AM_HL_INC, store: 1'b0, n_opnd: 2'd0};
      8'h32: dec_o = '{illegal: 1'b0, amode: AM_HL_DEC, store: 1'b1, n_opnd: 2'd0};
      8'h3A: dec_o = '{illegal: 1'b0, amode: AM_HL_DEC, store: 1'b0, n_opnd: 2'd0};
      8'hE0: dec_o = '{illegal: 1'b0, amode: AM_PAGE_N, store: 1'b1, n_opnd: 2'd1};
      8'hF0: dec_o = '{illegal: 1'b0, amode: AM_PAGE_N, store: 1'b0, n_opnd: 2'd1};
      8'hE2: dec_o = '{illegal: 1'b0, amode: AM_PAGE_C, store: 1'b1, n_opnd: 2'd0};
      8'hF2: dec_o = '{illegal: 1'b0, amode: AM_PAGE_C, store: 1'b0, n_opnd: 2'd0};
      8'hEA: dec_o = '{illegal: 1'b0, amode: AM_ABS,    store: 1'b1, n_opnd: 2'd2};
      8'hFA: dec_o = '{illegal: 1'b0, amode: AM_ABS,    store: 1'b0, n_opnd: 2'd2};
      8'h08: dec_o = '{illegal: 1'b0, amode: AM_SP_ABS, store: 1'b1, n_opnd: 2'd2};
      8'hD3, 8'hDB, 8'hDD, 8'hE3, 8'hE4, 8'hEB,
      8'hEC, 8'hED, 8'hF4, 8'hFC, 8'hFD:
        dec_o = '{illegal: 1'b1, amode: AM_NONE, store: 1'b0, n_opnd: 2'd0};
      default: ;
    endcase
  end

endmodule

// File: rtl/ls_addr_gen.sv
module ls_addr_gen
  import ls_pkg::*;
(
  input  ls_state_e   state_i,
  input  ls_amode_e   amode_i,
  input  logic [15:0] pc_i,
  input  logic [15:0] hl_i,
  input  logic [7:0]  c_i,
  input  logic [15:0] opnd_i,
  output logic [15:0] addr_o
);

  always_comb begin
    addr_o = pc_i;
    case (state_i)
      ST_XFER: begin
        case (amode_i)
          AM_HL_INC, AM_HL_DEC: addr_o = hl_i;
          AM_PAGE_N:            addr_o = {PAGE_HI, opnd_i[7:0]};
          AM_PAGE_C:            addr_o = {PAGE_HI, c_i};
          AM_ABS, AM_SP_ABS:    addr_o = opnd_i;
          default:              addr_o = pc_i;
        endcase
      end
      ST_XFER2: addr_o = opnd_i + 16'd1;  // wraps modulo 2^16
      default:  addr_o = pc_i;
    endcase
  end

endmodule

// File: rtl/ls_microseq.sv
module ls_microseq
  import ls_pkg::*;
#(
  parameter int          MCYC_CLKS = 4,
  parameter logic [15:0] PC_RST    = 16'h0000,
  parameter logic [7:0]  A_RST     = 8'h00,
  parameter logic [7:0]  C_RST     = 8'h12,
  parameter logic [15:0] HL_RST    = 16'hFFFE,
  parameter logic [15:0] SP_RST    = 16'hBEEF
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  output logic [15:0] mem_addr_o,
  output logic        mem_rd_o,
  output logic        mem_wr_o,
  output logic [7:0]  mem_wdata_o,
  input  logic [7:0]  mem_rdata_i,
  output logic [7:0]  reg_a_o,
  output logic [7:0]  reg_c_o,
  output logic [15:0] reg_hl_o,
  output logic [15:0] reg_sp_o,
  output logic        done_o,
  output logic        locked_o
);

  localparam int            PH_W      = $clog2(MCYC_CLKS);
  localparam logic [PH_W-1:0] STROBE_PH = PH_W'(1);
  localparam logic [PH_W-1:0] LAST_PH   = PH_W'(MCYC_CLKS - 1);

  ls_state_e       state_q, state_d;
  logic [PH_W-1:0] ph_q;
  logic [15:0]     pc_q, hl_q, sp_q;
  logic [7:0]      op_q, lo_q, hi_q, a_q, c_q;
  ls_dec_t         dec;
  logic            strobe, last, fetching;

  ls_decode u_dec (.op_i(op_q), .dec_o(dec));

  ls_addr_gen u_agen (
    .state_i (state_q),
    .amode_i (dec.amode),
    .pc_i    (pc_q),
    .hl_i    (hl_q),
    .c_i     (c_q),
    .opnd_i  ({hi_q, lo_q}),
    .addr_o  (mem_addr_o)
  );

  assign strobe   = (state_q != ST_LOCK) && (ph_q == STROBE_PH);
  assign last     = (ph_q == LAST_PH);
  assign fetching = (state_q == ST_FETCH) || (state_q == ST_OPLO) || (state_q == ST_OPHI);

  assign mem_rd_o = strobe && (fetching || (state_q == ST_XFER && !dec.store));
  assign mem_wr_o = strobe && ((state_q == ST_XFER && dec.store) || state_q == ST_XFER2);
  assign mem_wdata_o = (state_q == ST_XFER2)     ? sp_q[15:8] :
                       (dec.amode == AM_SP_ABS)  ? sp_q[7:0]  : a_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_FETCH: begin
        if (dec.illegal)              state_d = ST_LOCK;
        else if (dec.amode == AM_NONE) state_d = ST_FETCH;
        else if (dec.n_opnd != 2'd0)  state_d = ST_OPLO;
        else                          state_d = ST_XFER;
      end
      ST_OPLO:  state_d = (dec.n_opnd == 2'd2) ? ST_OPHI : ST_XFER;
      ST_OPHI:  state_d = ST_XFER;
      ST_XFER:  state_d = (dec.amode == AM_SP_ABS) ? ST_XFER2 : ST_FETCH;
      ST_XFER2: state_d = ST_FETCH;
      default:  state_d = ST_LOCK;
    endcase
  end

  assign done_o = last && (
      (state_q == ST_FETCH && !dec.illegal && dec.amode == AM_NONE) ||
      (state_q == ST_XFER && dec.amode != AM_SP_ABS) ||
      (state_q == ST_XFER2));
  assign locked_o = (state_q == ST_LOCK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FETCH;
      ph_q    <= '0;
      pc_q    <= PC_RST;
      op_q    <= 8'h00;
      lo_q    <= 8'h00;
      hi_q    <= 8'h00;
      a_q     <= A_RST;
      hl_q    <= HL_RST;
    end else begin
      ph_q <= last ? '0 : ph_q + 1'b1;
      if (strobe) begin
        case (state_q)
          ST_FETCH: begin op_q <= mem_rdata_i; pc_q <= pc_q + 16'd1; end
          ST_OPLO:  begin lo_q <= mem_rdata_i; pc_q <= pc_q + 16'd1; end
          ST_OPHI:  begin hi_q <= mem_rdata_i; pc_q <= pc_q + 16'd1; end
          ST_XFER: begin
            if (!dec.store) a_q <= mem_rdata_i;
            if (dec.amode == AM_HL_INC) hl_q <= hl_q + 16'd1;
            if (dec.amode == AM_HL_DEC) hl_q <= hl_q - 16'd1;
          end
          default: ;
        endcase
      end
      if (last) state_q <= state_d;
    end
  end

  // C and SP are held here; no instruction in this subset changes them
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_q  <= C_RST;
      sp_q <= SP_RST;
    end else begin
      c_q  <= c_q;
      sp_q <= sp_q;
    end
  end

  assign reg_a_o  = a_q;
  assign reg_c_o  = c_q;
  assign reg_hl_o = hl_q;
  assign reg_sp_o = sp_q;

  a_r2_rd_wr_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));

  a_r2_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o || mem_wr_o) |=> !(mem_rd_o || mem_wr_o));

  a_r3_hl_post_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mem_rd_o || mem_wr_o) && state_q == ST_XFER && dec.amode == AM_HL_INC)
      |=> hl_q == $past(hl_q) + 16'd1);

  a_r4_hl_post_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mem_rd_o || mem_wr_o) && state_q == ST_XFER && dec.amode == AM_HL_DEC)
      |=> hl_q == $past(hl_q) - 16'd1);

  a_r5_page_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mem_rd_o || mem_wr_o) && state_q == ST_XFER &&
     (dec.amode == AM_PAGE_N || dec.amode == AM_PAGE_C))
      |-> mem_addr_o[15:8] == 8'hFF);

  a_r9_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |=> locked_o);

  a_r9_lock_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |-> !mem_rd_o && !mem_wr_o && !done_o);

  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

endmodule

// File: tb/ls_microseq_test.sv
module ls_microseq_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0]  A0  = 8'h00;
  localparam logic [7:0]  C0  = 8'h12;
  localparam logic [15:0] HL0 = 16'hFFFE;
  localparam logic [15:0] SP0 = 16'hBEEF;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr, done, locked;
  logic [7:0]  mem_wdata, mem_rdata, reg_a, reg_c;
  logic [15:0] reg_hl, reg_sp;

  ls_microseq uut (
    .clk_i(clk), .rst_ni(rst_ni), .mem_addr_o(mem_addr), .mem_rd_o(mem_rd),
    .mem_wr_o(mem_wr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .reg_a_o(reg_a), .reg_c_o(reg_c), .reg_hl_o(reg_hl), .reg_sp_o(reg_sp),
    .done_o(done), .locked_o(locked)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [1:0]  ev;    // 0 read, 1 write, 2 done
    logic [15:0] addr;
    logic [7:0]  data;
    logic [7:0]  a;
    logic [15:0] hl;
    logic [7:0]  dur;
  } exp_t;

  exp_t        q[$];
  string       qtag[$];
  logic [7:0]  prog [256];
  int          checks = 0, errors = 0;
  int          cyc = 0, last_done = -1;
  logic [15:0] m_pc, m_hl;
  logic [7:0]  m_a;

  function automatic logic [7:0] dval(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] rval(logic [15:0] a);
    return (a < 16'h0100) ? prog[a[7:0]] : dval(a);
  endfunction

  assign mem_rdata = rval(mem_addr);

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(logic [1:0] ev, logic [15:0] addr, logic [7:0] data,
                      logic [7:0] dur, string tag);
    q.push_back('{ev: ev, addr: addr, data: data, a: m_a, hl: m_hl, dur: dur});
    qtag.push_back(tag);
  endtask

  task automatic emit(logic [7:0] b, string tag);
    prog[m_pc[7:0]] = b;
    push(2'd0, m_pc, 8'h00, 8'd0, tag);
    m_pc = m_pc + 16'd1;
  endtask

  // driver: lays the instruction into memory and queues the expected bus events
  task automatic ins(logic [7:0] op, logic [7:0] b1, logic [7:0] b2);
    logic [15:0] nn;
    nn = {b2, b1};
    case (op)
      8'h22: begin emit(op, "R3 fetch"); push(2'd1, m_hl, m_a, 0, "R3 write");
             m_hl = m_hl + 16'd1; push(2'd2, 0, 0, 8, "R3 done"); end
      8'h2A: begin emit(op, "R3 fetch"); push(2'd0, m_hl, 0, 0, "R3 read");
             m_a = rval(m_hl); m_hl = m_hl + 16'd1; push(2'd2, 0, 0, 8, "R3 done"); end
      8'h32: begin emit(op, "R4 fetch"); push(2'd1, m_hl, m_a, 0, "R4 write");
             m_hl = m_hl - 16'd1; push(2'd2, 0, 0, 8, "R4 done"); end
      8'h3A: begin emit(op, "R4 fetch"); push(2'd0, m_hl, 0, 0, "R4 read");
             m_a = rval(m_hl); m_hl = m_hl - 16'd1; push(2'd2, 0, 0, 8, "R4 done"); end
      8'hE0: begin emit(op, "R5 fetch"); emit(b1, "R5 operand");
             push(2'd1, {8'hFF, b1}, m_a, 0, "R5 write"); push(2'd2, 0, 0, 12, "R5 done"); end
      8'hF0: begin emit(op, "R5 fetch"); emit(b1, "R5 operand");
             push(2'd0, {8'hFF, b1}, 0, 0, "R5 read"); m_a = rval({8'hFF, b1});
             push(2'd2, 0, 0, 12, "R5 done"); end
      8'hE2: begin emit(op, "R6 fetch"); push(2'd1, {8'hFF, C0}, m_a, 0, "R6 write");
             push(2'd2, 0, 0, 8, "R6 done"); end
      8'hF2: begin emit(op, "R6 fetch"); push(2'd0, {8'hFF, C0}, 0, 0, "R6 read");
             m_a = rval({8'hFF, C0}); push(2'd2, 0, 0, 8, "R6 done"); end
      8'hEA: begin emit(op, "R7 fetch"); emit(b1, "R7 lo"); emit(b2, "R7 hi");
             push(2'd1, nn, m_a, 0, "R7 write"); push(2'd2, 0, 0, 16, "R7 done"); end
      8'hFA: begin emit(op, "R7 fetch"); emit(b1, "R7 lo"); emit(b2, "R7 hi");
             push(2'd0, nn, 0, 0, "R7 read"); m_a = rval(nn); push(2'd2, 0, 0, 16, "R7 done"); end
      8'h08: begin emit(op, "R8 fetch"); emit(b1, "R8 lo"); emit(b2, "R8 hi");
             push(2'd1, nn, SP0[7:0], 0, "R8 low byte");
             push(2'd1, nn + 16'd1, SP0[15:8], 0, "R8 high byte");
             push(2'd2, 0, 0, 20, "R8 done"); end
      default: begin emit(op, "R10 fetch"); push(2'd2, 0, 0, 4, "R10 done"); end
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_ni) cyc <= 0;
    else         cyc <= cyc + 1;
  end

  // monitor: pops expected items as the design produces events
  always @(negedge clk) begin
    if (!rst_ni) begin
      last_done = -1;
    end else begin
      if (mem_rd || mem_wr) begin
        if (q.size() == 0) begin
          check(0, "R9 unexpected strobe", {15'd0, mem_rd, mem_addr}, 32'd0);
        end else begin
          exp_t e;
          string t;
          e = q.pop_front();
          t = qtag.pop_front();
          check(e.ev == (mem_wr ? 2'd1 : 2'd0), {t, " R2 kind"}, {31'd0, mem_wr}, {30'd0, e.ev});
          check(mem_addr == e.addr, {t, " addr"}, {16'd0, mem_addr}, {16'd0, e.addr});
          if (mem_wr) check(mem_wdata == e.data, {t, " data"}, {24'd0, mem_wdata}, {24'd0, e.data});
        end
      end
      if (done) begin
        if (q.size() == 0) begin
          check(0, "R9 unexpected done", 32'd1, 32'd0);
        end else begin
          exp_t e;
          string t;
          e = q.pop_front();
          t = qtag.pop_front();
          check(e.ev == 2'd2, {t, " R11 done order"}, 32'd2, {30'd0, e.ev});
          check(reg_a == e.a, {t, " A"}, {24'd0, reg_a}, {24'd0, e.a});
          check(reg_hl == e.hl, {t, " HL"}, {16'd0, reg_hl}, {16'd0, e.hl});
          check(cyc - last_done == int'(e.dur), {t, " R11 duration"}, cyc - last_done, {24'd0, e.dur});
          last_done = cyc;
        end
      end
    end
  end

  task automatic drain(string tag);
    int guard;
    guard = 0;
    while (q.size() != 0 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    check(q.size() == 0, tag, q.size(), 0);
  endtask

  initial begin
    logic [7:0] bad [11];
    bad = '{8'hD3, 8'hDB, 8'hDD, 8'hE3, 8'hE4, 8'hEB, 8'hEC, 8'hED, 8'hF4, 8'hFC, 8'hFD};
    for (int i = 0; i < 256; i++) prog[i] = 8'h00;
    m_pc = 16'h0000; m_a = A0; m_hl = HL0;

    ins(8'h00, 0, 0);       // R10 skipped opcode
    ins(8'h2A, 0, 0);       // R3 load from FFFE
    ins(8'h22, 0, 0);       // R3 store FFFF, HL wraps to 0000
    ins(8'h32, 0, 0);       // R4 store 0000, HL wraps to FFFF
    ins(8'h3A, 0, 0);       // R4 load FFFF
    ins(8'hE0, 8'h80, 0);   // R5
    ins(8'hF0, 8'h44, 0);   // R5
    ins(8'hE0, 8'hFF, 0);   // R5 no carry at top of page
    ins(8'hE2, 0, 0);       // R6
    ins(8'hF2, 0, 0);       // R6
    ins(8'hEA, 8'h34, 8'h12); // R7
    ins(8'hFA, 8'hCD, 8'hAB); // R7
    ins(8'h08, 8'hFF, 8'hC0); // R8
    ins(8'h08, 8'hFF, 8'hFF); // R8 second byte wraps to 0000
    ins(8'h47, 0, 0);       // R10
    emit(8'hD3, "R9 fetch");

    repeat (3) @(negedge clk);
    check(reg_a == A0,   "R1 A",  {24'd0, reg_a},  {24'd0, A0});
    check(reg_c == C0,   "R1 C",  {24'd0, reg_c},  {24'd0, C0});
    check(reg_hl == HL0, "R1 HL", {16'd0, reg_hl}, {16'd0, HL0});
    check(reg_sp == SP0, "R1 SP", {16'd0, reg_sp}, {16'd0, SP0});
    check(!locked && !mem_rd && !mem_wr && !done, "R1 quiet",
          {28'd0, locked, mem_rd, mem_wr, done}, 32'd0);
    rst_ni = 1'b1;
    drain("R2 program completion");
    repeat (40) @(negedge clk);
    check(locked == 1'b1, "R9 locked after program", {31'd0, locked}, 32'd1);
    check(reg_sp == SP0, "R8 SP unchanged", {16'd0, reg_sp}, {16'd0, SP0});

    foreach (bad[k]) begin
      rst_ni = 1'b0;
      q.delete(); qtag.delete();
      prog[0] = bad[k];
      m_pc = 16'h0000;
      emit(bad[k], "R9 fetch");
      repeat (2) @(negedge clk);
      check(!locked, "R1 lock cleared by reset", {31'd0, locked}, 32'd0);
      rst_ni = 1'b1;
      repeat (3) @(negedge clk);
      check(!locked, "R9 not locked before fetch end", {31'd0, locked}, 32'd0);
      @(negedge clk);
      check(locked, "R9 locked at fetch end", {24'd0, bad[k]}, 32'd1);
      repeat (30) @(negedge clk);
      check(locked && q.size() == 0, "R9 stays locked", {31'd0, locked}, 32'd1);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule